// File: doc/BRIEF.md
# Dual-Channel Timer with Buffered Compare and Pin Capture

This block is a free-running up-counter with two channels that watch it. Channel A is either a compare register that flags when the counter reaches its value or a capture register that stores the counter on a chosen edge of its pin. Channel B offers four modes: direct compare, compare through a holding buffer, capture on one chosen pin edge, and capture on every pin edge. Each channel raises its own one-cycle interrupt pulse.

Buffered compare lets software change the period safely. A write to channel B goes to a holding buffer and the active compare value stays unchanged. The buffer is copied into the active register only on a reload event, and every reload event also returns the counter to zero. Four conditions cause a reload: an explicit timer initialization pulse, counter overflow when channel A is not chained in, a channel A compare hit when it is, and a channel A capture when it is. Channel B can also return the counter to zero on its own compare hit, which gives a period of the compare value plus one.

Both capture pins pass through a two-flop synchronizer. An edge is found by comparing the newest synchronized sample with the one before it. All register access goes through a simple write strobe and a combinational read mux. The block has no stream data path, so no valid/ready handshake is used and all pins are plain control or status.

Top module: `timer_cc_dual`

## Requirements
- R1: After reset the counter, channel A, channel B, the holding buffer, irq_a and irq_b are all zero.
- R2: The counter adds one on each clock where cnt_en is 1. It holds its value when cnt_en is 0. It wraps from 0xFFFF to 0x0000.
- R3: When channel B is in a compare mode (b_mode 0 = direct compare, 1 = buffered compare) and the counter equals the active B value on a counting clock, irq_b is 1 for the following cycle.
- R4: With b_clr_en = 1, a channel B compare hit returns the counter to zero. Interrupts then repeat every N+1 cycles, where N is the B value, and the first one comes N+1 clocks after initialization.
- R5: In buffered compare mode, a write to address 1 updates only the holding buffer. Reading address 1 keeps returning the previous active value until a reload event.
- R6: A tmr_init pulse sets the counter to 0x0000 and, in buffered compare mode, copies the buffer to the active B value.
- R7: With a_reload_en = 0, a counter overflow from 0xFFFF reloads B from the buffer, and the counter becomes 0x0000.
- R8: With a_reload_en = 1 and channel A in compare mode (a_cap_mode = 0), a counter match with channel A on a counting clock reloads B from the buffer and sets the counter to 0x0000.
- R9: With a_reload_en = 1 and channel A in capture mode (a_cap_mode = 1), a channel A capture stores the counter into A, reloads B from the buffer and sets the counter to 0x0000.
- R10: In single-edge capture (b_mode 2), the edge chosen by b_edge_rise (1 = rising, 0 = falling) stores the counter into B and pulses irq_b. The opposite edge has no effect. The capture happens on the third clock edge after the pin changes, and stores the counter value held just before that edge.
- R11: In dual-edge capture (b_mode 3), both rising and falling pin edges capture into B and pulse irq_b, with the same latency as R10.
- R12: If a write to B and a reload happen on the same clock, the active value takes the old buffer contents and the buffer takes the new data.
- R13: irq_a pulses for one cycle after a channel A compare hit or capture.
- R14: reg_rdata shows channel A at address 0, active channel B at address 1, the counter at address 2, and zero at address 3. Writes go to A at address 0 and to B at address 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_en | input | 1 | Counter advance enable |
| tmr_init | input | 1 | Timer initialization pulse |
| a_reload_en | input | 1 | Chain channel A events into buffer reload |
| a_cap_mode | input | 1 | Channel A mode: 0 compare, 1 capture |
| a_edge_rise | input | 1 | Channel A capture edge: 1 rising, 0 falling |
| b_mode | input | 2 | Channel B mode: 0 compare, 1 buffered compare, 2 single-edge capture, 3 dual-edge capture |
| b_edge_rise | input | 1 | Channel B single-edge select: 1 rising, 0 falling |
| b_clr_en | input | 1 | Counter clears on channel B compare hit |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for write and read |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr |
| cap_a_pin | input | 1 | Asynchronous channel A capture pin |
| cap_b_pin | input | 1 | Asynchronous channel B capture pin |
| irq_a | output | 1 | Channel A interrupt pulse |
| irq_b | output | 1 | Channel B interrupt pulse |

## Verification
The periodic compare mode is run with several compare values, including zero. Checking both the first interrupt and the spacing between interrupts separates a correct N+1 period from an off-by-one in the clear or the match. Each of the four reload triggers is set up with a fresh buffered value, and the active value is read just before and just after the trigger, so that a reload that comes early, late or from the wrong source shows up. Capture is driven with the selected edge, the opposite edge and both edges while the counter runs, so the exact captured count confirms the synchronizer latency and the edge choice.

// File: rtl/tcc_pkg.sv
package tcc_pkg;
  localparam int unsigned CNT_W = 16;

  typedef enum logic [1:0] {
    BM_CMP  = 2'd0,
    BM_DBUF = 2'd1,
    BM_CAP1 = 2'd2,
    BM_CAP2 = 2'd3
  } b_mode_e;

  localparam logic [1:0] ADDR_A   = 2'd0;
  localparam logic [1:0] ADDR_B   = 2'd1;
  localparam logic [1:0] ADDR_CNT = 2'd2;
endpackage

// File: rtl/tcc_edge_det.sv
module tcc_edge_det #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise = sync_q[STAGES-1] & ~prev_q;
  assign fall = ~sync_q[STAGES-1] & prev_q;

  // R10
  rise_once_chk: assert property (@(posedge clk) disable iff (!rst_n) rise |=> !rise);
  // R11
  fall_once_chk: assert property (@(posedge clk) disable iff (!rst_n) fall |=> !fall);
endmodule

// File: rtl/tcc_counter.sv
module tcc_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_en,
  input  logic         clr,
  output logic [W-1:0] cnt,
  output logic         at_max
);
  localparam logic [W-1:0] MAX_VAL = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (clr)    cnt <= '0;
    else if (cnt_en) cnt <= cnt + 1'b1;
  end

  assign at_max = (cnt == MAX_VAL);

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && !clr) |=> cnt == W'($past(cnt) + 1'b1));
  // R2
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !clr) |=> $stable(cnt));
  // R6
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt == '0);
endmodule

// File: rtl/tcc_chan_a.sv
module tcc_chan_a #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap_mode,
  input  logic         edge_rise,
  input  logic         rise,
  input  logic         fall,
  input  logic [W-1:0] cnt,
  input  logic         cnt_en,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] value,
  output logic         match,
  output logic         cap_evt,
  output logic         irq
);
  assign match   = !cap_mode && cnt_en && (cnt == value);
  assign cap_evt = cap_mode && (edge_rise ? rise : fall);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value <= '0;
      irq   <= 1'b0;
    end else begin
      irq <= match | cap_evt;
      if (cap_evt)    value <= cnt;
      else if (wr_en) value <= wdata;
    end
  end

  // R13
  a_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (match || cap_evt) |=> irq);
  // R9
  a_cap_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> value == $past(cnt));
endmodule

// File: rtl/tcc_chan_b.sv
module tcc_chan_b #(
  parameter int unsigned W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tcc_pkg::b_mode_e  mode,
  input  logic              edge_rise,
  input  logic              rise,
  input  logic              fall,
  input  logic [W-1:0]      cnt,
  input  logic              cnt_en,
  input  logic              wr_en,
  input  logic [W-1:0]      wdata,
  input  logic              load,
  output logic [W-1:0]      active,
  output logic              match,
  output logic              irq
);
  import tcc_pkg::*;

  logic [W-1:0] buf_q;
  logic         is_cmp;
  logic         cap_evt;

  assign is_cmp = (mode == BM_CMP) || (mode == BM_DBUF);
  assign match  = is_cmp && cnt_en && (cnt == active);

  always_comb begin
    unique case (mode)
      BM_CAP1: cap_evt = edge_rise ? rise : fall;
      BM_CAP2: cap_evt = rise | fall;
      default: cap_evt = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q  <= '0;
      active <= '0;
      irq    <= 1'b0;
    end else begin
      irq <= match | cap_evt;
      if (wr_en) buf_q <= wdata;
      if (cap_evt)                    active <= cnt;
      else if (mode == BM_DBUF) begin
        if (load)                     active <= buf_q;
      end else if (wr_en)             active <= wdata;
    end
  end

  // R5
  dbuf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == BM_DBUF && !load) |=> $stable(active));
  // R12
  dbuf_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == BM_DBUF && load) |=> active == $past(buf_q));
  // R10
  b_cap_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> (irq && active == $past(cnt)));
  // R3
  b_match_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> irq);
endmodule

// File: rtl/timer_cc_dual.sv
module timer_cc_dual #(
  parameter int unsigned W          = tcc_pkg::CNT_W,
  parameter int unsigned SYNC_STAGE = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_en,
  input  logic         tmr_init,
  input  logic         a_reload_en,
  input  logic         a_cap_mode,
  input  logic         a_edge_rise,
  input  logic [1:0]   b_mode,
  input  logic         b_edge_rise,
  input  logic         b_clr_en,
  input  logic         reg_wr,
  input  logic [1:0]   reg_addr,
  input  logic [W-1:0] reg_wdata,
  output logic [W-1:0] reg_rdata,
  input  logic         cap_a_pin,
  input  logic         cap_b_pin,
  output logic         irq_a,
  output logic         irq_b
);
  import tcc_pkg::*;

  logic [W-1:0] cnt;
  logic         at_max;
  logic         a_rise, a_fall, b_rise, b_fall;
  logic [W-1:0] a_val, b_val;
  logic         a_match, a_cap, b_match;
  logic         reload_evt, cnt_clr;
  b_mode_e      b_mode_t;

  assign b_mode_t = b_mode_e'(b_mode);

  tcc_edge_det #(.STAGES(SYNC_STAGE)) u_edge_a (
    .clk(clk), .rst_n(rst_n), .pin(cap_a_pin), .rise(a_rise), .fall(a_fall));

  tcc_edge_det #(.STAGES(SYNC_STAGE)) u_edge_b (
    .clk(clk), .rst_n(rst_n), .pin(cap_b_pin), .rise(b_rise), .fall(b_fall));

  assign reload_evt = tmr_init
                    | (!a_reload_en && cnt_en && at_max)
                    | (a_reload_en && (a_match || a_cap));
  assign cnt_clr    = reload_evt | (b_clr_en && b_match);

  tcc_counter #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .clr(cnt_clr),
    .cnt(cnt), .at_max(at_max));

  tcc_chan_a #(.W(W)) u_chan_a (
    .clk(clk), .rst_n(rst_n), .cap_mode(a_cap_mode), .edge_rise(a_edge_rise),
    .rise(a_rise), .fall(a_fall), .cnt(cnt), .cnt_en(cnt_en),
    .wr_en(reg_wr && reg_addr == ADDR_A), .wdata(reg_wdata),
    .value(a_val), .match(a_match), .cap_evt(a_cap), .irq(irq_a));

  tcc_chan_b #(.W(W)) u_chan_b (
    .clk(clk), .rst_n(rst_n), .mode(b_mode_t), .edge_rise(b_edge_rise),
    .rise(b_rise), .fall(b_fall), .cnt(cnt), .cnt_en(cnt_en),
    .wr_en(reg_wr && reg_addr == ADDR_B), .wdata(reg_wdata),
    .load(reload_evt), .active(b_val), .match(b_match), .irq(irq_b));

  always_comb begin
    unique case (reg_addr)
      ADDR_A:   reg_rdata = a_val;
      ADDR_B:   reg_rdata = b_val;
      ADDR_CNT: reg_rdata = cnt;
      default:  reg_rdata = '0;
    endcase
  end

  // R8
  reload_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reload_evt |=> cnt == '0);
  // R7
  overflow_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && at_max) |=> cnt == '0);
  // R4
  b_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (b_clr_en && b_match) |=> (cnt == '0 && irq_b));
endmodule

// File: tb/timer_cc_dual_tb_top.sv
`timescale 1ns/100ps
module timer_cc_dual_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_en = 0, tmr_init = 0, a_reload_en = 0, a_cap_mode = 0, a_edge_rise = 0;
  logic [1:0]  b_mode = 2'd0;
  logic        b_edge_rise = 0, b_clr_en = 0, reg_wr = 0;
  logic [1:0]  reg_addr = 2'd0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        cap_a_pin = 0, cap_b_pin = 0;
  logic        irq_a, irq_b;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  timer_cc_dual dut_i (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .tmr_init(tmr_init),
    .a_reload_en(a_reload_en), .a_cap_mode(a_cap_mode), .a_edge_rise(a_edge_rise),
    .b_mode(b_mode), .b_edge_rise(b_edge_rise), .b_clr_en(b_clr_en),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cap_a_pin(cap_a_pin), .cap_b_pin(cap_b_pin), .irq_a(irq_a), .irq_b(irq_b));

  // compare value, expected first pulse / spacing (both N+1)
  localparam logic [31:0] VEC [4] = '{
    {16'd3,  16'd4},
    {16'd7,  16'd8},
    {16'd0,  16'd1},
    {16'd20, 16'd21}
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 0;
  endtask

  task automatic init_pulse();
    tmr_init = 1;
    tick();
    tmr_init = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    int first, second;
    bit seen;
    repeat (3) tick();
    rst_n = 1;
    tick();

    // R1 reset state
    rd(2'd0, d); chk(d == 16'h0, "R1 A reset", d, 0);
    rd(2'd1, d); chk(d == 16'h0, "R1 B reset", d, 0);
    rd(2'd2, d); chk(d == 16'h0, "R1 counter reset", d, 0);
    chk(!irq_a && !irq_b, "R1 irq reset", {irq_a, irq_b}, 0);

    // R14 read mux, R2 hold and count
    wr(2'd0, 16'h0055);
    rd(2'd0, d); chk(d == 16'h0055, "R14 A readback", d, 16'h55);
    rd(2'd3, d); chk(d == 16'h0, "R14 addr3 zero", d, 0);
    repeat (3) tick();
    rd(2'd2, d); chk(d == 16'h0, "R2 hold", d, 0);
    cnt_en = 1; repeat (5) tick(); cnt_en = 0;
    rd(2'd2, d); chk(d == 16'd5, "R2 count", d, 5);

    // R3 R4 periodic compare, vector table
    b_mode = 2'd0; b_clr_en = 1;
    foreach (VEC[i]) begin
      wr(2'd1, VEC[i][31:16]);
      init_pulse();
      first = 0; second = 0;
      cnt_en = 1;
      for (int c = 1; c <= 60; c++) begin
        tick();
        if (irq_b) begin
          if (first == 0) first = c;
          else if (second == 0) second = c;
        end
      end
      cnt_en = 0;
      chk(first == int'(VEC[i][15:0]), "R3 first irq", first, VEC[i][15:0]);
      chk(second - first == int'(VEC[i][15:0]), "R4 period", second - first, VEC[i][15:0]);
    end

    // R5 R6 R12 buffered compare
    b_clr_en = 0; b_mode = 2'd1;
    tick();
    wr(2'd1, 16'h0ABC);
    rd(2'd1, d); chk(d == 16'd20, "R5 old value visible", d, 20);
    cnt_en = 1; repeat (2) tick(); cnt_en = 0;
    init_pulse();
    rd(2'd1, d); chk(d == 16'h0ABC, "R6 init loads", d, 16'hABC);
    rd(2'd2, d); chk(d == 16'h0, "R6 init zero", d, 0);
    wr(2'd1, 16'h0222);
    reg_wr = 1; reg_addr = 2'd1; reg_wdata = 16'h0111; tmr_init = 1;
    tick();
    reg_wr = 0; tmr_init = 0;
    rd(2'd1, d); chk(d == 16'h0222, "R12 load uses old buffer", d, 16'h222);
    init_pulse();
    rd(2'd1, d); chk(d == 16'h0111, "R12 new data kept", d, 16'h111);

    // R8 reload on channel A match, R13
    a_reload_en = 1;
    wr(2'd0, 16'd6);
    wr(2'd1, 16'h0333);
    cnt_en = 1; repeat (6) tick();
    rd(2'd2, d); chk(d == 16'd6, "R8 counter before match", d, 6);
    rd(2'd1, d); chk(d == 16'h0111, "R8 B before match", d, 16'h111);
    tick(); cnt_en = 0;
    rd(2'd2, d); chk(d == 16'h0, "R8 counter zeroed", d, 0);
    rd(2'd1, d); chk(d == 16'h0333, "R8 B loaded", d, 16'h333);
    chk(irq_a, "R13 irq_a on match", irq_a, 1);

    // R9 reload on channel A capture
    a_cap_mode = 1; a_edge_rise = 1;
    init_pulse();
    wr(2'd1, 16'h0444);
    cnt_en = 1; repeat (10) tick();
    cap_a_pin = 1;
    repeat (2) tick();
    rd(2'd1, d); chk(d == 16'h0333, "R9 B before capture", d, 16'h333);
    tick(); cnt_en = 0;
    rd(2'd0, d); chk(d == 16'd12, "R9 A captured", d, 12);
    rd(2'd2, d); chk(d == 16'h0, "R9 counter zeroed", d, 0);
    rd(2'd1, d); chk(d == 16'h0444, "R9 B loaded", d, 16'h444);
    chk(irq_a, "R13 irq_a on capture", irq_a, 1);
    a_reload_en = 0; cap_a_pin = 0;
    repeat (4) tick();

    // R10 single-edge capture, falling selected
    b_mode = 2'd2; b_edge_rise = 0;
    init_pulse();
    cnt_en = 1; cap_b_pin = 1;
    seen = 0;
    repeat (5) begin tick(); if (irq_b) seen = 1; end
    chk(!seen, "R10 rising ignored irq", seen, 0);
    rd(2'd1, d); chk(d == 16'h0444, "R10 rising ignored value", d, 16'h444);
    cap_b_pin = 0;
    repeat (3) tick();
    rd(2'd1, d); chk(d == 16'd7, "R10 falling capture", d, 7);
    chk(irq_b, "R10 irq_b", irq_b, 1);

    // R11 dual-edge capture
    b_mode = 2'd3;
    cap_b_pin = 1;
    repeat (3) tick();
    rd(2'd1, d); chk(d == 16'd10, "R11 rising capture", d, 10);
    chk(irq_b, "R11 irq_b rise", irq_b, 1);
    cap_b_pin = 0;
    repeat (3) tick();
    rd(2'd1, d); chk(d == 16'd13, "R11 falling capture", d, 13);
    chk(irq_b, "R11 irq_b fall", irq_b, 1);
    cnt_en = 0;

    // R7 reload on overflow, R2 wrap
    b_mode = 2'd1;
    init_pulse();
    wr(2'd1, 16'h0555);
    cnt_en = 1;
    repeat (65535) tick();
    rd(2'd2, d); chk(d == 16'hFFFF, "R2 reach max", d, 16'hFFFF);
    rd(2'd1, d); chk(d == 16'h0444, "R7 B before overflow", d, 16'h444);
    tick(); cnt_en = 0;
    rd(2'd2, d); chk(d == 16'h0, "R2 wrap", d, 0);
    rd(2'd1, d); chk(d == 16'h0555, "R7 B loaded", d, 16'h555);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule